// File: doc/BRIEF.md
# DMA Transfer Length Splitter

This block cuts one memory segment, given as a start address and a byte length, into a run of pieces. Each piece is small enough for one buffer slot of a DMA channel. An oversized segment is not cut into full-size chunks followed by a short tail. The block works out the fewest pieces that fit, gives each one a near-equal length that is a multiple of four bytes, and repeats that calculation on whatever length is left after each piece.

A cyclic mode serves ring buffers. The total size is divided into equal periods, each period is split by the same rule, and the final piece of every period carries a period-end flag. Commands arrive on a valid/ready port. Pieces leave on a valid/ready stream of address, length, period-end and last. A command the block cannot serve produces a one-cycle error pulse. The division runs on a serial divider, so the command port stays closed while a command is being worked on.

Top module: `len_splitter`

## Requirements
- R1: No piece is longer than 0x1FFF bytes, and no piece is empty. A segment (or period) of at most 0x1FFF bytes is emitted whole, as a single piece.
- R2: While the remaining length of a segment exceeds 0x1FFF, the next piece is sized from the piece count n = ceil(remaining / 0x1FFC). Its length is floor(remaining / n) with bits [1:0] cleared, so every piece except the final one of a segment is a multiple of 4. This calculation is made again on the new remainder after each piece.
- R3: The first piece starts at the command address. Every later piece of the command starts at the previous piece's address plus the previous piece's length.
- R4: A command whose address has bit 0 or bit 1 set is rejected. err_pulse is high for exactly the cycle after acceptance, and no piece is emitted.
- R5: A command of length zero is rejected in the same way. So is a cyclic command whose period is zero or larger than the total size.
- R6: In cyclic mode (cmd_cyclic=1), floor(size / period) periods are emitted back to back. Each is split by R1 and R2, and the final piece of each period has out_period_end=1. In non-cyclic mode out_period_end is always 0.
- R7: In cyclic mode a size that is not a whole multiple of the period leaves a tail. The tail is not emitted, and err_pulse is high in the cycle after the final piece is accepted.
- R8: out_last is 1 only on the final piece of a command: the final piece of the segment when non-cyclic, or the final piece of the final whole period when cyclic.
- R9: cmd_ready is 1 only while idle. It is 0 from the cycle after a good command is accepted, through every division, until the final piece has been accepted.
- R10: While out_valid=1 and out_ready=0, the piece is held: out_valid stays 1 and out_addr and out_len do not change.
- R11: After a synchronous reset (rst_n=0 at a clock edge), cmd_ready=1, out_valid=0 and err_pulse=0, and any command in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block is idle and will take a command |
| cmd_addr | input | AW | Start address of the segment |
| cmd_len | input | LW | Segment length in bytes (total size in cyclic mode) |
| cmd_cyclic | input | 1 | Selects cyclic mode |
| cmd_period | input | LW | Period length in bytes, used only in cyclic mode |
| out_valid | output | 1 | A piece is presented |
| out_ready | input | 1 | The consumer takes the piece |
| out_addr | output | AW | Start address of the piece |
| out_len | output | LW | Length of the piece in bytes |
| out_period_end | output | 1 | Final piece of a period (cyclic mode only) |
| out_last | output | 1 | Final piece of the command |
| err_pulse | output | 1 | One-cycle pulse when a command is rejected or a cyclic tail is dropped |

## Verification
The bench attacks the boundary at 0x1FFF and just above it. A splitter that used full-size chunks, or that rounded the count the wrong way, would emit 0x1FFC plus a short tail there instead of two equal halves. Odd lengths that need several division passes catch a design that computes the piece size only once: its final piece would differ, and its addresses would drift. Cyclic runs with multi-piece periods and with a leftover tail expose a period-end or last flag on the wrong piece, and a tail that is emitted rather than flagged. Misaligned addresses, zero length, zero period and a period larger than the size must each give a lone error pulse with no pieces. Throughout, the output stream is stalled at random points, which would reveal a piece changing under backpressure or the command port reopening during a division.

// File: rtl/lsplit_pkg.sv
// Package: shared types for the length splitter.
// Assumes: nothing beyond IEEE 1800-2017.
package lsplit_pkg;

    // Sequencer states of the splitter.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a command
        ST_PLAN,   // decide: emit remainder whole or divide
        ST_DCNT,   // divider computes the piece count
        ST_DLEN,   // divider computes the piece length
        ST_EMIT    // piece presented on the output stream
    } lsplit_state_e;

endpackage

// File: rtl/lsplit_div.sv
// Module: serial restoring divider, one quotient bit per clock.
// Does: on start, loads dividend and divisor and, W cycles later, pulses
//       done with quotient and remainder valid from that cycle on.
// Assumes: divisor is non-zero when start is raised; start is taken at
//          any time and restarts the division.
module lsplit_div #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, r_r, b_r;
    logic [CW-1:0] cnt_r;
    logic [W:0]    wide;
    logic          ge;
    logic [W:0]    diff;

    // One trial subtraction of the shifted partial remainder.
    always_comb begin
        wide = {r_r, q_r[W-1]};
        diff = wide - {1'b0, b_r};
        ge   = (wide >= {1'b0, b_r});
    end

    // Iteration register: shift, subtract, count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            r_r   <= '0;
            b_r   <= '0;
            cnt_r <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_r   <= dividend;
                r_r   <= '0;
                b_r   <= divisor;
                cnt_r <= CW'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                q_r   <= {q_r[W-2:0], ge};
                r_r   <= ge ? diff[W-1:0] : wide[W-1:0];
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r;

    // R2: a finished division leaves a remainder below the divisor.
    p_rem_below_divisor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < b_r));

    // R2: done is only raised when the iteration ends.
    p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/lsplit_check.sv
// Module: command screen for the length splitter.
// Does: flags a command that must be rejected (misaligned start, empty
//       length, or a cyclic command that yields no whole period).
// Assumes: purely combinational; evaluated while the command is offered.
module lsplit_check #(
    parameter int LW = 20
) (
    input  logic [1:0]    addr_lo,
    input  logic [LW-1:0] len,
    input  logic          cyclic,
    input  logic [LW-1:0] period,
    output logic          bad_align,
    output logic          bad
);
    logic bad_len;

    // Decide whether the command can produce any piece.
    always_comb begin
        bad_align = (addr_lo != 2'b00);
        bad_len   = (len == '0) || (cyclic && ((period == '0) || (len < period)));
        bad       = bad_align || bad_len;
    end

endmodule

// File: rtl/len_splitter.sv
// Module: DMA transfer length splitter (top).
// Does: accepts a segment (or a ring of equal periods) and streams out
//       pieces no longer than MAX_PIECE, sized as near-equal 4-byte
//       multiples, with period-end and last flags; rejects bad commands
//       with a one-cycle err_pulse.
// Assumes: LW >= 13 so MAX_PIECE fits; one command in flight at a time.
module len_splitter
    import lsplit_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LW        = 20,
    parameter int MAX_PIECE = 8191
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_cyclic,
    input  logic [LW-1:0] cmd_period,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic [LW-1:0] out_len,
    output logic          out_period_end,
    output logic          out_last,
    output logic          err_pulse
);
    localparam int            ALIGN_LIM = MAX_PIECE & ~3;
    localparam logic [LW-1:0] MAX_L     = LW'(MAX_PIECE);
    localparam logic [LW-1:0] LIM_L     = LW'(ALIGN_LIM);

    lsplit_state_e state;
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] tot_rem, seg_rem, per, piece;
    logic          cyc;
    logic          err_q;

    logic          cmd_bad, cmd_bad_align;
    logic          div_start, div_busy, div_done;
    logic [LW-1:0] div_a, div_b, div_q, div_r;
    logic [LW-1:0] cnt_up, tot_next;
    logic          seg_end, period_more;

    lsplit_check #(.LW(LW)) u_check (
        .addr_lo   (cmd_addr[1:0]),
        .len       (cmd_len),
        .cyclic    (cmd_cyclic),
        .period    (cmd_period),
        .bad_align (cmd_bad_align),
        .bad       (cmd_bad)
    );

    lsplit_div #(.W(LW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (div_q),
        .rem      (div_r)
    );

    // Piece count rounded up, and where the ring stands after this period.
    always_comb begin
        cnt_up      = div_q + LW'(div_r != '0);
        tot_next    = tot_rem - per;
        seg_end     = (piece == seg_rem);
        period_more = cyc && (tot_next >= per);
    end

    // Divider launch: count first, then length using that count.
    always_comb begin
        div_start = 1'b0;
        div_a     = seg_rem;
        div_b     = LIM_L;
        if (state == ST_PLAN && seg_rem > MAX_L) begin
            div_start = 1'b1;
        end else if (state == ST_DCNT && div_done) begin
            div_start = 1'b1;
            div_b     = cnt_up;
        end
    end

    // Sequencer: accept, plan, divide, emit, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            tot_rem  <= '0;
            seg_rem  <= '0;
            per      <= '0;
            piece    <= '0;
            cyc      <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            cur_addr <= cmd_addr;
                            tot_rem  <= cmd_len;
                            per      <= cmd_period;
                            cyc      <= cmd_cyclic;
                            seg_rem  <= cmd_cyclic ? cmd_period : cmd_len;
                            state    <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN: begin
                    if (seg_rem <= MAX_L) begin
                        piece <= seg_rem;
                        state <= ST_EMIT;
                    end else begin
                        state <= ST_DCNT;
                    end
                end
                ST_DCNT: begin
                    if (div_done) state <= ST_DLEN;
                end
                ST_DLEN: begin
                    if (div_done) begin
                        piece <= {div_q[LW-1:2], 2'b00};
                        state <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        cur_addr <= cur_addr + AW'(piece);
                        if (!seg_end) begin
                            seg_rem <= seg_rem - piece;
                            state   <= ST_PLAN;
                        end else if (period_more) begin
                            tot_rem <= tot_next;
                            seg_rem <= per;
                            state   <= ST_PLAN;
                        end else begin
                            err_q <= cyc && (tot_next != '0);
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready      = (state == ST_IDLE);
    assign out_valid      = (state == ST_EMIT);
    assign out_addr       = cur_addr;
    assign out_len        = piece;
    assign out_period_end = cyc && seg_end;
    assign out_last       = seg_end && !period_more;
    assign err_pulse      = err_q;

    // R1: every presented piece is non-empty and within the slot limit.
    p_piece_in_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len <= MAX_L) && (out_len != '0));

    // R2: pieces that close nothing are 4-byte multiples.
    p_inner_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last && !out_period_end) |-> (out_len[1:0] == 2'b00));

    // R4: a rejected command never leaves a piece behind it.
    p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_bad_align) |=> (!out_valid && err_pulse));

    // R6: in cyclic mode the final piece also closes a period.
    p_cyc_last_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && cyc) |-> out_period_end);

    // R9: the command port is shut while the divider works.
    p_busy_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !cmd_ready);

    // R10: a stalled piece is held unchanged.
    p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)));

endmodule

// File: tb/tb_len_splitter.sv
`timescale 1ns/1ps
module tb_len_splitter;
    localparam int AW = 32;
    localparam int LW = 20;

    typedef struct packed {
        logic [31:0] addr;
        logic [19:0] len;
        logic        cyc;
        logic [19:0] per;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 20'h00100, 1'b0, 20'h00000},  // small, whole
        '{32'h0000_2000, 20'h01FFF, 1'b0, 20'h00000},  // exactly the limit
        '{32'h0000_4000, 20'h02000, 1'b0, 20'h00000},  // just over: two halves
        '{32'h0001_0000, 20'h04000, 1'b0, 20'h00000},  // three passes
        '{32'h0002_0002, 20'h00040, 1'b0, 20'h00000},  // misaligned
        '{32'h0000_3000, 20'h00000, 1'b0, 20'h00000},  // zero length
        '{32'h0000_8000, 20'h03000, 1'b1, 20'h01000},  // ring, 1 piece/period
        '{32'h0000_9000, 20'h06000, 1'b1, 20'h03000},  // ring, 2 pieces/period
        '{32'h0000_A000, 20'h02500, 1'b1, 20'h01000},  // ring with tail
        '{32'h0000_B000, 20'h00800, 1'b1, 20'h01000},  // period > size
        '{32'h0000_C000, 20'h00100, 1'b1, 20'h00000},  // zero period
        '{32'h0010_0000, 20'h09001, 1'b0, 20'h00000},  // odd, many passes
        '{32'h0000_0000, 20'hFFFFF, 1'b0, 20'h00000}   // largest length
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_cyclic = 1'b0;
    logic [LW-1:0] cmd_period = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_addr;
    logic [LW-1:0] out_len;
    logic          out_period_end;
    logic          out_last;
    logic          err_pulse;

    int checks = 0;
    int errors = 0;
    int ph = 0;

    longint exp_addr[$], exp_len[$];
    bit     exp_pend[$], exp_last[$];
    bit     exp_err;
    longint act_addr[$], act_len[$];
    bit     act_pend[$], act_last[$];

    always #10 clk = ~clk;

    len_splitter #(.AW(AW), .LW(LW), .MAX_PIECE(8191)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_cyclic(cmd_cyclic), .cmd_period(cmd_period),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_len(out_len), .out_period_end(out_period_end), .out_last(out_last),
        .err_pulse(err_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference split of one segment, from R1/R2/R3.
    task automatic push_seg(inout longint a, input longint l, input bit is_cyc,
                            input bit final_seg);
        longint r = l;
        while (r > 8191) begin
            longint n = (r + 8187) / 8188;
            longint p = (r / n) & ~longint'(3);
            exp_addr.push_back(a); exp_len.push_back(p);
            exp_pend.push_back(1'b0); exp_last.push_back(1'b0);
            a += p; r -= p;
        end
        exp_addr.push_back(a); exp_len.push_back(r);
        exp_pend.push_back(is_cyc); exp_last.push_back(final_seg);
        a += r;
    endtask

    task automatic model(input vec_t v);
        longint a = longint'(v.addr);
        exp_addr.delete(); exp_len.delete(); exp_pend.delete(); exp_last.delete();
        exp_err = 1'b0;
        if (v.addr[1:0] != 2'b00 || v.len == 0 || (v.cyc && (v.per == 0 || v.len < v.per))) begin
            exp_err = 1'b1;
        end else if (!v.cyc) begin
            push_seg(a, longint'(v.len), 1'b0, 1'b1);
        end else begin
            int np = int'(v.len / v.per);
            for (int i = 0; i < np; i++) push_seg(a, longint'(v.per), 1'b1, i == np - 1);
            exp_err = (v.len % v.per) != 0;
        end
    endtask

    task automatic run_vec(input int idx);
        vec_t  v = VECS[idx];
        bit    got_err = 1'b0, got_last = 1'b0, stalled = 1'b0, port_ok = 1'b1;
        int    tail = 0;
        longint st_addr = 0, st_len = 0;
        string err_tag, cnt_tag;
        model(v);
        act_addr.delete(); act_len.delete(); act_pend.delete(); act_last.delete();
        err_tag = (v.addr[1:0] != 0) ? "R4" : (v.len == 0 || (v.cyc && (v.per == 0 || v.len < v.per))) ? "R5"
                : v.cyc ? "R7" : "R4";
        cnt_tag = (v.len <= 8191) ? "R1" : "R2";
        @(negedge clk);
        check(cmd_ready == 1'b1, "R9", "ready when idle", longint'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_addr = v.addr; cmd_len = v.len;
        cmd_cyclic = v.cyc; cmd_period = v.per;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c < 40000; c++) begin
            ph++;
            out_ready = (ph % 4) != 3;
            #1;
            if (stalled) begin
                check(out_valid && longint'(out_addr) == st_addr && longint'(out_len) == st_len,
                      "R10", "held piece", longint'(out_len), st_len);
            end
            stalled = out_valid && !out_ready;
            st_addr = longint'(out_addr); st_len = longint'(out_len);
            if (err_pulse) got_err = 1'b1;
            if (!got_last && !got_err && !exp_err && cmd_ready) port_ok = 1'b0;
            if (out_valid && out_ready) begin
                act_addr.push_back(longint'(out_addr)); act_len.push_back(longint'(out_len));
                act_pend.push_back(out_period_end); act_last.push_back(out_last);
                if (out_last) got_last = 1'b1;
            end
            if (got_last || got_err) tail++;
            if (tail > 3) break;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(port_ok, "R9", "cmd_ready low while busy", longint'(port_ok), 1);
        check(got_err == exp_err, err_tag, "error pulse", longint'(got_err), longint'(exp_err));
        check(act_len.size() == exp_len.size(), cnt_tag, "piece count",
              longint'(act_len.size()), longint'(exp_len.size()));
        if (act_len.size() == exp_len.size()) begin
            for (int i = 0; i < exp_len.size(); i++) begin
                check(act_len[i] == exp_len[i], cnt_tag, "piece length", act_len[i], exp_len[i]);
                check(act_addr[i] == exp_addr[i], "R3", "piece address", act_addr[i], exp_addr[i]);
                check(act_pend[i] == exp_pend[i], "R6", "period end", longint'(act_pend[i]), longint'(exp_pend[i]));
                check(act_last[i] == exp_last[i], "R8", "last flag", longint'(act_last[i]), longint'(exp_last[i]));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle state after reset
        check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", longint'(cmd_ready), 1);
        check(out_valid == 1'b0, "R11", "out_valid after reset", longint'(out_valid), 0);
        check(err_pulse == 1'b0, "R11", "err_pulse after reset", longint'(err_pulse), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R11: reset in the middle of a long command drops it
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 32'h0004_0000; cmd_len = 20'h09001; cmd_cyclic = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(cmd_ready == 1'b0, "R9", "port shut mid-command", longint'(cmd_ready), 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        check(cmd_ready == 1'b1, "R11", "cmd_ready after mid reset", longint'(cmd_ready), 1);
        check(out_valid == 1'b0, "R11", "out_valid after mid reset", longint'(out_valid), 0);
        out_ready = 1'b0;

        // Screened command after recovery still splits correctly (R1)
        run_vec(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule